// File: doc/BRIEF.md
# Shared GPIO Bank with Per-Group Write Ownership

This block is one 32-line general-purpose I/O bank whose control registers are visible to three register masters at once: the main processor (master 0), a host-side bus (master 1) and a coprocessor (master 2). The lines are split into four groups of eight. Every group has a two-bit owner code, and only the owning master's writes reach that group's bits in the data-path registers. Writes from other masters to those bits are dropped without any response. Every master can read every register.

Software hands a group to the coprocessor by programming the owner code, and takes it back the same way. The block keeps the output latch separate from the sampled pin state. A read of the value register returns what the pins show after a two-flop synchronizer. A separate readback register returns what was last written to the latch. If an owner code ever holds the reserved pattern, the block locks that group against every master and raises a sticky error for the main processor.

Top module: `gpio_bank_arbiter`

## Requirements
- R1: After reset, both owner registers are zero, so the main processor owns all groups. The latch, direction, interrupt enable, interrupt status, tolerance, debounce select and error registers are all zero, as are every master's read data, `pin_out`, `pin_oe` and `irq`.
- R2: A write to the value register (0x00) by the owner sets the output latch, which drives `pin_out`. A read of 0x00 returns the synchronized pin state, including lines driven as outputs, and a read that starts together with a pin change still returns the old state. The readback register (0x08) returns the latch, and writes to 0x08 change nothing.
- R3: The direction register at 0x04 drives `pin_oe` bit for bit, with 1 meaning output and 0 meaning input.
- R4: Group g covers lines 8g+7..8g. Its owner code has its low bit at bit 8g of register 0x20 and its high bit at bit 8g of register 0x24. Code 0 selects master 0, code 1 selects master 1 and code 2 selects master 2.
- R5: For the value, direction, interrupt enable, interrupt status and tolerance registers, a write changes only the bits of groups owned by the writer. All other bits keep their value.
- R6: While a group's code is 3, writes from all masters to that group's bits in the owner-gated registers are ignored. Such a write sets a sticky error flag, read as bit 0 of 0x1C by master 0 only (other masters read 0). Master 0 clears the flag by writing 1 to that bit.
- R7: Only master 0 can write the owner registers, and only bits 0, 8, 16 and 24 are stored. All other bits read as 0.
- R8: An interrupt status bit (0x10) sets when its synchronized input changes level while its enable bit (0x0C) is 1. Writing 1 clears the bit, and a set in the same cycle takes priority over the clear. `irq` is high while any bit has both status and enable set.
- R9: Any master can write the debounce select register (0x18) at any time, regardless of owner codes. When several masters write it in the same cycle, master 0 takes priority over master 1, and master 1 over master 2. The register drives `db_sel`.
- R10: Read data is registered. It appears after the clock edge that samples `bus_rd` and holds until that master's next read.
- R11: The tolerance register (0x14) is owner-gated and drives `tol_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3x6 | Byte address for each master (index 0 main, 1 host, 2 coprocessor) |
| bus_wdata | input | 3x32 | Write data for each master |
| bus_wr | input | 3 | Write strobe for each master |
| bus_rd | input | 3 | Read strobe for each master |
| bus_rdata | output | 3x32 | Registered read data for each master |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enables (direction) |
| tol_out | output | 32 | Reset-tolerance bits |
| db_sel | output | 32 | Debounce timer select bits |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the embedded properties check four things. The owner registers never change unless master 0 writes them. A group whose code is 3 keeps its latch and direction bits. The latch stays still when no master writes the value register. The error flag stays set until master 0 clears it. A further property checks that each newly set interrupt status bit traces back to an enabled level change. The bench scenarios cover the rest: the mixed-owner merge values, the one-cycle staleness of value reads, the silence of the readback register, the error bit being hidden from the other masters, write-one-to-clear gating by owner, and the priority of simultaneous debounce writes.

// File: rtl/gpio_arb_pkg.sv
`timescale 1ns/1ps
package gpio_arb_pkg;
    localparam int NUM_SRC   = 3;
    localparam int NUM_GATED = 5;

    localparam logic [1:0] SRC_MAIN  = 2'd0;
    localparam logic [1:0] SRC_HOST  = 2'd1;
    localparam logic [1:0] SRC_COPRO = 2'd2;
    localparam logic [1:0] SRC_BAD   = 2'd3;

    typedef enum logic [3:0] {
        RG_VALUE = 4'd0,
        RG_DIR   = 4'd1,
        RG_LATCH = 4'd2,
        RG_IEN   = 4'd3,
        RG_IST   = 4'd4,
        RG_TOL   = 4'd5,
        RG_DBS   = 4'd6,
        RG_ERR   = 4'd7,
        RG_SRC0  = 4'd8,
        RG_SRC1  = 4'd9
    } reg_sel_e;

    localparam int GT_VALUE = 0;
    localparam int GT_DIR   = 1;
    localparam int GT_IEN   = 2;
    localparam int GT_IST   = 3;
    localparam int GT_TOL   = 4;

    function automatic reg_sel_e gated_reg(input int k);
        case (k)
            GT_VALUE: return RG_VALUE;
            GT_DIR:   return RG_DIR;
            GT_IEN:   return RG_IEN;
            GT_IST:   return RG_IST;
            default:  return RG_TOL;
        endcase
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/gpio_owner_merge.sv
`timescale 1ns/1ps
module gpio_owner_merge
    import gpio_arb_pkg::*;
#(
    parameter int LINES   = 32,
    parameter int GROUP_W = 8,
    localparam int GROUPS = LINES / GROUP_W
) (
    input  logic [GROUPS-1:0][1:0]        grp_code,
    input  logic [NUM_SRC-1:0]            hit,
    input  logic [NUM_SRC-1:0][LINES-1:0] wdata,
    output logic [LINES-1:0]              wmask,
    output logic [LINES-1:0]              wval,
    output logic                          blocked
);
    logic [GROUPS-1:0] blk;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic               take;
        logic [GROUP_W-1:0] pick;

        always_comb begin
            take = 1'b0;
            pick = '0;
            case (grp_code[g])
                SRC_MAIN: begin
                    take = hit[0];
                    pick = wdata[0][g*GROUP_W +: GROUP_W];
                end
                SRC_HOST: begin
                    take = hit[1];
                    pick = wdata[1][g*GROUP_W +: GROUP_W];
                end
                SRC_COPRO: begin
                    take = hit[2];
                    pick = wdata[2][g*GROUP_W +: GROUP_W];
                end
                default: begin
                    take = 1'b0;
                    pick = '0;
                end
            endcase
        end

        assign wmask[g*GROUP_W +: GROUP_W] = {GROUP_W{take}};
        assign wval[g*GROUP_W +: GROUP_W]  = take ? pick : '0;
        assign blk[g] = (grp_code[g] == SRC_BAD) && (|hit);
    end

    assign blocked = |blk;
endmodule

// File: rtl/gpio_read_mux.sv
`timescale 1ns/1ps
module gpio_read_mux
    import gpio_arb_pkg::*;
#(
    parameter int LINES   = 32,
    parameter int ADDR_W  = 6,
    parameter bit IS_MAIN = 1'b0,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LINES-1:0]  pins_sync,
    input  logic [LINES-1:0]  dir,
    input  logic [LINES-1:0]  latch,
    input  logic [LINES-1:0]  ien,
    input  logic [LINES-1:0]  ist,
    input  logic [LINES-1:0]  tol,
    input  logic [LINES-1:0]  dbs,
    input  logic              err,
    input  logic [LINES-1:0]  src0,
    input  logic [LINES-1:0]  src1,
    output logic [LINES-1:0]  rword
);
    always_comb begin
        case (word)
            WORD_W'(RG_VALUE): rword = pins_sync;
            WORD_W'(RG_DIR):   rword = dir;
            WORD_W'(RG_LATCH): rword = latch;
            WORD_W'(RG_IEN):   rword = ien;
            WORD_W'(RG_IST):   rword = ist;
            WORD_W'(RG_TOL):   rword = tol;
            WORD_W'(RG_DBS):   rword = dbs;
            WORD_W'(RG_ERR):   rword = IS_MAIN ? {{(LINES-1){1'b0}}, err} : '0;
            WORD_W'(RG_SRC0):  rword = src0;
            WORD_W'(RG_SRC1):  rword = src1;
            default:           rword = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_arbiter.sv
`timescale 1ns/1ps
module gpio_bank_arbiter
    import gpio_arb_pkg::*;
#(
    parameter int LINES   = 32,
    parameter int GROUP_W = 8,
    parameter int ADDR_W  = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0][ADDR_W-1:0]    bus_addr,
    input  logic [NUM_SRC-1:0][LINES-1:0]     bus_wdata,
    input  logic [NUM_SRC-1:0]                bus_wr,
    input  logic [NUM_SRC-1:0]                bus_rd,
    output logic [NUM_SRC-1:0][LINES-1:0]     bus_rdata,
    input  logic [LINES-1:0]                  pin_in,
    output logic [LINES-1:0]                  pin_out,
    output logic [LINES-1:0]                  pin_oe,
    output logic [LINES-1:0]                  tol_out,
    output logic [LINES-1:0]                  db_sel,
    output logic                              irq
);
    localparam int GROUPS = LINES / GROUP_W;
    localparam int WORD_W = ADDR_W - 2;

    function automatic logic [LINES-1:0] src_mask_f();
        logic [LINES-1:0] m;
        m = '0;
        for (int g = 0; g < GROUPS; g++) m[g*GROUP_W] = 1'b1;
        return m;
    endfunction
    localparam logic [LINES-1:0] SRC_MASK = src_mask_f();

    typedef struct packed {
        logic [LINES-1:0]              latch;
        logic [LINES-1:0]              dir;
        logic [LINES-1:0]              ien;
        logic [LINES-1:0]              ist;
        logic [LINES-1:0]              tol;
        logic [LINES-1:0]              dbs;
        logic [LINES-1:0]              src0;
        logic [LINES-1:0]              src1;
        logic [LINES-1:0]              pin_prev;
        logic                          err;
        logic [NUM_SRC-1:0][LINES-1:0] rdata;
    } state_t;

    state_t st_q, st_d;

    logic [LINES-1:0]                    pins_sync;
    logic [LINES-1:0]                    edge_v;
    logic [NUM_SRC-1:0][WORD_W-1:0]      word;
    logic [NUM_SRC-1:0][1:0]             unused_addr_lsb;
    logic [GROUPS-1:0][1:0]              grp_code;
    logic [NUM_GATED-1:0][NUM_SRC-1:0]   gate_hit;
    logic [NUM_GATED-1:0][LINES-1:0]     wmask;
    logic [NUM_GATED-1:0][LINES-1:0]     wval;
    logic [NUM_GATED-1:0]                blk;
    logic [NUM_SRC-1:0][LINES-1:0]       rd_word;
    logic                                main_src_wr;
    logic                                main_err_clr;

    gpio_in_sync #(.WIDTH(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    always_comb begin
        for (int m = 0; m < NUM_SRC; m++) begin
            word[m]            = bus_addr[m][ADDR_W-1:2];
            unused_addr_lsb[m] = bus_addr[m][1:0];
        end
        for (int g = 0; g < GROUPS; g++) begin
            grp_code[g] = {st_q.src1[g*GROUP_W], st_q.src0[g*GROUP_W]};
        end
        for (int k = 0; k < NUM_GATED; k++) begin
            for (int m = 0; m < NUM_SRC; m++) begin
                gate_hit[k][m] = bus_wr[m] && (word[m] == WORD_W'(gated_reg(k)));
            end
        end
    end

    for (genvar k = 0; k < NUM_GATED; k++) begin : g_gate
        gpio_owner_merge #(.LINES(LINES), .GROUP_W(GROUP_W)) u_merge (
            .grp_code (grp_code),
            .hit      (gate_hit[k]),
            .wdata    (bus_wdata),
            .wmask    (wmask[k]),
            .wval     (wval[k]),
            .blocked  (blk[k])
        );
    end

    for (genvar m = 0; m < NUM_SRC; m++) begin : g_rd
        gpio_read_mux #(.LINES(LINES), .ADDR_W(ADDR_W), .IS_MAIN(m == 0)) u_rmux (
            .word      (word[m]),
            .pins_sync (pins_sync),
            .dir       (st_q.dir),
            .latch     (st_q.latch),
            .ien       (st_q.ien),
            .ist       (st_q.ist),
            .tol       (st_q.tol),
            .dbs       (st_q.dbs),
            .err       (st_q.err),
            .src0      (st_q.src0),
            .src1      (st_q.src1),
            .rword     (rd_word[m])
        );
    end

    assign edge_v       = pins_sync ^ st_q.pin_prev;
    assign main_src_wr  = bus_wr[0] && ((word[0] == WORD_W'(RG_SRC0)) || (word[0] == WORD_W'(RG_SRC1)));
    assign main_err_clr = bus_wr[0] && (word[0] == WORD_W'(RG_ERR)) && bus_wdata[0][0];

    always_comb begin
        st_d = st_q;
        st_d.pin_prev = pins_sync;
        st_d.latch = (st_q.latch & ~wmask[GT_VALUE]) | wval[GT_VALUE];
        st_d.dir   = (st_q.dir   & ~wmask[GT_DIR])   | wval[GT_DIR];
        st_d.ien   = (st_q.ien   & ~wmask[GT_IEN])   | wval[GT_IEN];
        st_d.tol   = (st_q.tol   & ~wmask[GT_TOL])   | wval[GT_TOL];
        st_d.ist   = (st_q.ist & ~(wmask[GT_IST] & wval[GT_IST])) | (edge_v & st_q.ien);
        for (int m = NUM_SRC - 1; m >= 0; m--) begin
            if (bus_wr[m] && (word[m] == WORD_W'(RG_DBS))) st_d.dbs = bus_wdata[m];
        end
        if (bus_wr[0] && (word[0] == WORD_W'(RG_SRC0))) st_d.src0 = bus_wdata[0] & SRC_MASK;
        if (bus_wr[0] && (word[0] == WORD_W'(RG_SRC1))) st_d.src1 = bus_wdata[0] & SRC_MASK;
        st_d.err = (|blk) | (st_q.err & ~main_err_clr);
        for (int m = 0; m < NUM_SRC; m++) begin
            if (bus_rd[m]) st_d.rdata[m] = rd_word[m];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out   = st_q.latch;
    assign pin_oe    = st_q.dir;
    assign tol_out   = st_q.tol;
    assign db_sel    = st_q.dbs;
    assign bus_rdata = st_q.rdata;
    assign irq       = |(st_q.ist & st_q.ien);

    // Owner registers move only on a main-processor write (R7)
    assert_src_main_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !main_src_wr |=> ($stable(st_q.src0) && $stable(st_q.src1)));

    // Error flag stays up until master 0 clears it (R6)
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !main_err_clr) |=> st_q.err);

    // No value-register write from anyone leaves the latch untouched (R5)
    assert_latch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gate_hit[GT_VALUE]) |=> $stable(st_q.latch));

    // A newly set status bit needs an enabled level change one cycle earlier (R8)
    assert_ist_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ist & ~$past(st_q.ist)) != '0) |->
        (((st_q.ist & ~$past(st_q.ist)) & ~($past(edge_v) & $past(st_q.ien))) == '0));

    for (genvar g = 0; g < GROUPS; g++) begin : g_freeze
        // Reserved owner code freezes the group's data bits (R6)
        assert_reserved_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_code[g] == SRC_BAD) |=>
            ($stable(st_q.latch[g*GROUP_W +: GROUP_W]) && $stable(st_q.dir[g*GROUP_W +: GROUP_W])));
    end
endmodule

// File: tb/tb_gpio_bank_arbiter.sv
`timescale 1ns/1ps
module tb_gpio_bank_arbiter;
    localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_LAT = 6'h08, A_IEN = 6'h0C,
                           A_IST = 6'h10, A_TOL = 6'h14, A_DBS = 6'h18, A_ERR = 6'h1C,
                           A_S0  = 6'h20, A_S1  = 6'h24;
    localparam int NROWS = 37;
    // {req[4], is_read[1], master[2], addr[6], data_or_expected[32]}
    localparam logic [44:0] TBL [NROWS] = '{
        {4'd2, 1'b0, 2'd0, A_VAL, 32'hA5A51234},
        {4'd2, 1'b1, 2'd0, A_LAT, 32'hA5A51234},   // R2 latch readback
        {4'd5, 1'b0, 2'd1, A_VAL, 32'hFFFFFFFF},
        {4'd5, 1'b1, 2'd0, A_LAT, 32'hA5A51234},   // R5 host owns nothing
        {4'd4, 1'b0, 2'd0, A_S1,  32'h00010000},
        {4'd4, 1'b0, 2'd0, A_S0,  32'h00000100},
        {4'd4, 1'b1, 2'd1, A_S0,  32'h00000100},   // R4
        {4'd4, 1'b1, 2'd2, A_S1,  32'h00010000},   // R4
        {4'd4, 1'b0, 2'd1, A_VAL, 32'hFFFFFFFF},
        {4'd4, 1'b1, 2'd0, A_LAT, 32'hA5A5FF34},   // R4 host takes group 1
        {4'd4, 1'b0, 2'd2, A_VAL, 32'h00000000},
        {4'd4, 1'b1, 2'd0, A_LAT, 32'hA500FF34},   // R4 coprocessor takes group 2
        {4'd5, 1'b0, 2'd0, A_VAL, 32'h11111111},
        {4'd5, 1'b1, 2'd0, A_LAT, 32'h1100FF11},   // R5
        {4'd3, 1'b0, 2'd2, A_DIR, 32'hFFFFFFFF},
        {4'd3, 1'b1, 2'd0, A_DIR, 32'h00FF0000},   // R3 / R5
        {4'd7, 1'b0, 2'd1, A_S0,  32'hFFFFFFFF},
        {4'd7, 1'b1, 2'd0, A_S0,  32'h00000100},   // R7 host cannot write owners
        {4'd6, 1'b1, 2'd0, A_ERR, 32'h00000000},   // R6 no error yet
        {4'd7, 1'b0, 2'd0, A_S0,  32'hFFFFFFFF},
        {4'd7, 1'b1, 2'd0, A_S0,  32'h01010101},   // R7 only control bits kept
        {4'd6, 1'b0, 2'd1, A_VAL, 32'h55555555},
        {4'd6, 1'b1, 2'd0, A_LAT, 32'h55005555},   // R6 group 2 frozen
        {4'd6, 1'b1, 2'd0, A_ERR, 32'h00000001},   // R6 error raised
        {4'd6, 1'b1, 2'd1, A_ERR, 32'h00000000},   // R6 hidden from host
        {4'd6, 1'b0, 2'd2, A_VAL, 32'hFFFFFFFF},
        {4'd6, 1'b1, 2'd0, A_LAT, 32'h55005555},   // R6
        {4'd6, 1'b0, 2'd0, A_ERR, 32'h00000001},
        {4'd6, 1'b1, 2'd0, A_ERR, 32'h00000000},   // R6 cleared
        {4'd9, 1'b0, 2'd2, A_DBS, 32'h12345678},
        {4'd9, 1'b1, 2'd1, A_DBS, 32'h12345678},   // R9 ungated
        {4'd2, 1'b0, 2'd0, A_S1,  32'h00000000},
        {4'd2, 1'b0, 2'd0, A_S0,  32'h00000000},
        {4'd2, 1'b0, 2'd0, A_LAT, 32'hFFFFFFFF},
        {4'd2, 1'b1, 2'd0, A_LAT, 32'h55005555},   // R2 readback write ignored
        {4'd11, 1'b0, 2'd0, A_TOL, 32'h0000FFFF},
        {4'd11, 1'b1, 2'd0, A_TOL, 32'h0000FFFF}   // R11
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0][5:0]   bus_addr = '0;
    logic [2:0][31:0]  bus_wdata = '0;
    logic [2:0]        bus_wr = '0;
    logic [2:0]        bus_rd = '0;
    logic [2:0][31:0]  bus_rdata;
    logic [31:0]       pin_in = '0;
    logic [31:0]       pin_out, pin_oe, tol_out, db_sel;
    logic              irq;
    int                checks = 0;
    int                errors = 0;
    logic [31:0]       rv;

    always #2.5 clk = ~clk;

    gpio_bank_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .tol_out(tol_out), .db_sel(db_sel), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(int m, logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr[m] = a; bus_wdata[m] = d; bus_wr[m] = 1'b1;
        @(negedge clk);
        bus_wr[m] = 1'b0;
    endtask

    task automatic do_rd(int m, logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr[m] = a; bus_rd[m] = 1'b1;
        @(negedge clk);
        bus_rd[m] = 1'b0;
        v = bus_rdata[m];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog all-requirements actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", pin_oe, 32'h0);
        chk("R1", pin_out, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);
        chk("R1", bus_rdata[0], 32'h0);
        do_rd(0, A_S0, rv); chk("R1", rv, 32'h0);
        do_rd(0, A_S1, rv); chk("R1", rv, 32'h0);

        for (int i = 0; i < NROWS; i++) begin
            logic [44:0] e;
            e = TBL[i];
            if (e[40]) begin
                do_rd(int'(e[39:38]), e[37:32], rv);
                chk($sformatf("R%0d", e[44:41]), rv, e[31:0]);
            end else begin
                do_wr(int'(e[39:38]), e[37:32], e[31:0]);
            end
        end

        // R2 value read is the synchronized pin, stale for one read
        @(negedge clk);
        pin_in = 32'hCAFEF00D; bus_addr[0] = A_VAL; bus_rd[0] = 1'b1;
        @(negedge clk);
        bus_rd[0] = 1'b0;
        chk("R2", bus_rdata[0], 32'h0);
        repeat (2) @(negedge clk);
        do_rd(0, A_VAL, rv); chk("R2", rv, 32'hCAFEF00D);
        // R10 read data holds between reads
        repeat (3) @(negedge clk);
        chk("R10", bus_rdata[0], 32'hCAFEF00D);

        // R3 direction to output enables, R2 latch to pins, R11 tolerance
        do_wr(0, A_DIR, 32'h0000FFFF);
        chk("R3", pin_oe, 32'h0000FFFF);
        chk("R2", pin_out, 32'h55005555);
        chk("R11", tol_out, 32'h0000FFFF);

        // R8 enabled change sets status, disabled change does not
        do_wr(0, A_IEN, 32'h00000003);
        @(negedge clk);
        pin_in = pin_in ^ 32'h00000011;
        repeat (4) @(negedge clk);
        chk("R8", {31'h0, irq}, 32'h1);
        do_rd(0, A_IST, rv); chk("R8", rv, 32'h00000001);
        do_wr(0, A_IST, 32'hFFFFFFFF);
        do_rd(0, A_IST, rv); chk("R8", rv, 32'h0);
        chk("R8", {31'h0, irq}, 32'h0);

        // R5 clear of status is owner-gated
        do_wr(0, A_S0, 32'h00000001);
        @(negedge clk);
        pin_in = pin_in ^ 32'h00000002;
        repeat (4) @(negedge clk);
        do_wr(0, A_IST, 32'h00000002);
        do_rd(0, A_IST, rv); chk("R5", rv, 32'h00000002);
        do_wr(1, A_IST, 32'h00000002);
        do_rd(0, A_IST, rv); chk("R5", rv, 32'h0);
        do_wr(0, A_S0, 32'h0);

        // R9 simultaneous debounce writes: master 0 wins
        @(negedge clk);
        bus_addr[0] = A_DBS; bus_wdata[0] = 32'hAAAA5555; bus_wr[0] = 1'b1;
        bus_addr[2] = A_DBS; bus_wdata[2] = 32'h0F0F0F0F; bus_wr[2] = 1'b1;
        @(negedge clk);
        bus_wr = '0;
        chk("R9", db_sel, 32'hAAAA5555);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule